// File: doc/BRIEF.md
# Processor Mode Control Register Unit

This unit keeps the handful of system control registers a simplified 32-bit processor core needs for its operating mode. It holds a mode word (protected-mode and paging enables), a fault-address register, a translation-table base register, a feature-control word and an extended-enable word. Software reaches them through a single write port and a combinational read port, each selected by a 3-bit register selector. The unit drives the table base, the paging, PAE and long-mode status and the protected-mode flag straight to downstream translation and decode logic.

It also acts as a permission oracle for the decoder. The decoder raises a one-cycle request for a debug-register access, a timestamp read, a performance-counter read, a wide media instruction or a virtualization instruction, and presents the current privilege level. On the next cycle the unit answers with a one-cycle invalid-opcode or general-protection pulse. For debug accesses it also gives back the remapped register index. Long-mode activity is never written. It is derived from the long-mode enable and the paging enable, and an ordering rule on writes protects it.

Top module: `mode_ctl_unit`

## Requirements
- R1: After reset every register reads 0 on every selector, and all status outputs, fault flags and the table base are 0.
- R2: Register selectors are 0 mode word, 1 fault address, 2 table base, 3 feature word, 4 extended word. The writable bits are: mode word bits 31 and 0; fault address all bits; table base bits 31:3; feature word bits 18 and 10:0; extended word bits 14:11 except 12's neighbours listed here (bits 14, 13, 12, 11), plus bits 8 and 0. All other bits, and selectors 5 to 7, read 0, and writes to them have no effect.
- R3: Extended-word bit 10 (long-mode active) cannot be written. It reads 1, and the `long_active` output is 1, exactly when extended bit 8 (long-mode enable) and mode bit 31 (paging) are both 1.
- R4: A write to the extended word that would change bit 8 while mode bit 31 is 1 leaves the whole register unchanged and pulses `gp_fault` for exactly one cycle after the write. A write that keeps bit 8 is accepted even with paging on.
- R5: With feature bit 3 clear, debug index 4 maps to 6 and 5 maps to 7, and other indices pass unchanged. With it set, indices pass unchanged, and a request for index 4 or 5 pulses `ud_fault` in the next cycle.
- R6: A timestamp read request pulses `gp_fault` in the next cycle only when feature bit 2 is 1 and the privilege level is not 0.
- R7: A performance-counter read request pulses `gp_fault` in the next cycle only when feature bit 8 is 0 and the privilege level is not 0.
- R8: A wide media request pulses `ud_fault` in the next cycle when feature bit 9 is 0, and does not when it is 1.
- R9: A virtualization request pulses `ud_fault` in the next cycle when extended bit 12 is 0, and does not when it is 1.
- R10: Table-base bits 4 and 3 drive `tbl_cd` and `tbl_wt`. With feature bit 5 (PAE) set, the base is bits 31:5 with the low 5 bits zero. With it clear, the base is bits 31:12 with the low 12 bits zero, and bits 11:5 read 0.
- R11: A page-fault strobe loads the fault-address register from `pf_addr`. It wins over a software write to the same register in the same cycle.
- R12: `prot_en` and `paging_en` follow mode bits 0 and 31, and `pae_en` follows feature bit 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| priv_lvl | input | 2 | Current privilege level, 0 most privileged |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register selected for write |
| wr_data | input | 32 | Write data |
| rd_sel | input | 3 | Register selected for read |
| rd_data | output | 32 | Read data (combinational) |
| pf_strobe | input | 1 | Page-fault capture strobe |
| pf_addr | input | 32 | Faulting address |
| dbg_req | input | 1 | Debug-register access request |
| dbg_idx | input | 3 | Requested debug-register index |
| dbg_map | output | 3 | Debug-register index after aliasing |
| op_tsc | input | 1 | Timestamp read request |
| op_pmc | input | 1 | Performance-counter read request |
| op_media | input | 1 | Wide media instruction request |
| op_virt | input | 1 | Virtualization instruction request |
| ud_fault | output | 1 | One-cycle invalid-opcode fault |
| gp_fault | output | 1 | One-cycle general-protection fault |
| prot_en | output | 1 | Protected mode enabled |
| paging_en | output | 1 | Paging enabled |
| pae_en | output | 1 | Physical-address extension enabled |
| long_active | output | 1 | Long mode active |
| tbl_base | output | 32 | Aligned top-level table base address |
| tbl_wt | output | 1 | Top-level table write-through |
| tbl_cd | output | 1 | Top-level table cache disable |

## Verification
A wrong stored bit shows on `rd_data` as soon as the edge that wrote it has passed. A mode or feature bit set wrongly shows just as quickly on the status outputs, on the debug index mapping and on the base alignment. A fault decision built on a wrong bit shows as a missing or extra pulse exactly one cycle after the request. A rejected long-mode change is watched on three things: the pulse, an unchanged extended word, and an unchanged `long_active`. A fault pulse that lasts longer than one cycle is caught on the cycle after it.

// File: rtl/mode_ctl_unit.sv
module mode_ctl_unit #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    priv_lvl,
  input  logic          wr_en,
  input  logic [2:0]    wr_sel,
  input  logic [DW-1:0] wr_data,
  input  logic [2:0]    rd_sel,
  output logic [DW-1:0] rd_data,
  input  logic          pf_strobe,
  input  logic [DW-1:0] pf_addr,
  input  logic          dbg_req,
  input  logic [2:0]    dbg_idx,
  output logic [2:0]    dbg_map,
  input  logic          op_tsc,
  input  logic          op_pmc,
  input  logic          op_media,
  input  logic          op_virt,
  output logic          ud_fault,
  output logic          gp_fault,
  output logic          prot_en,
  output logic          paging_en,
  output logic          pae_en,
  output logic          long_active,
  output logic [DW-1:0] tbl_base,
  output logic          tbl_wt,
  output logic          tbl_cd
);
  localparam logic [2:0] SEL_MODE = 3'd0, SEL_FADDR = 3'd1, SEL_TBASE = 3'd2,
                         SEL_FEAT = 3'd3, SEL_EXT = 3'd4;
  localparam logic [DW-1:0] MODE_MASK = DW'(32'h8000_0001);
  localparam logic [DW-1:0] FEAT_MASK = DW'(32'h0004_07FF);
  localparam logic [DW-1:0] EXT_MASK  = DW'(32'h0000_7901);

  logic [DW-1:0] mode_q, faddr_q, feat_q, ext_q;
  logic [DW-1:3] tbase_q;
  logic          gp_q, ud_q;

  logic lme, de, tsd, pce, fxsr, svme, priv0;
  assign lme   = ext_q[8];
  assign svme  = ext_q[12];
  assign tsd   = feat_q[2];
  assign de    = feat_q[3];
  assign pce   = feat_q[8];
  assign fxsr  = feat_q[9];
  assign priv0 = (priv_lvl == 2'd0);

  assign prot_en     = mode_q[0];
  assign paging_en   = mode_q[31];
  assign pae_en      = feat_q[5];
  assign long_active = lme & paging_en;

  logic ext_reject, dbg_bad, gp_next, ud_next;
  assign ext_reject = wr_en && wr_sel == SEL_EXT && paging_en && (wr_data[8] != lme);
  assign dbg_bad    = dbg_req && de && (dbg_idx == 3'd4 || dbg_idx == 3'd5);
  assign gp_next    = ext_reject | (op_tsc & tsd & ~priv0) | (op_pmc & ~pce & ~priv0);
  assign ud_next    = dbg_bad | (op_media & ~fxsr) | (op_virt & ~svme);

  assign dbg_map = (!de && dbg_idx[2:1] == 2'b10) ? {2'b11, dbg_idx[0]} : dbg_idx;

  logic [DW-1:0] tbase_view;
  assign tbase_view = pae_en ? {tbase_q[DW-1:5], tbase_q[4:3], 3'b000}
                             : {tbase_q[DW-1:12], 7'd0, tbase_q[4:3], 3'b000};
  assign tbl_base   = pae_en ? {tbase_q[DW-1:5], 5'd0} : {tbase_q[DW-1:12], 12'd0};
  assign tbl_wt     = tbase_q[3];
  assign tbl_cd     = tbase_q[4];
  assign gp_fault   = gp_q;
  assign ud_fault   = ud_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q  <= '0;
      faddr_q <= '0;
      tbase_q <= '0;
      feat_q  <= '0;
      ext_q   <= '0;
      gp_q    <= 1'b0;
      ud_q    <= 1'b0;
    end else begin
      gp_q <= gp_next;
      ud_q <= ud_next;
      if (pf_strobe) faddr_q <= pf_addr;
      else if (wr_en && wr_sel == SEL_FADDR) faddr_q <= wr_data;
      if (wr_en) begin
        case (wr_sel)
          SEL_MODE:  mode_q  <= wr_data & MODE_MASK;
          SEL_TBASE: tbase_q <= wr_data[DW-1:3];
          SEL_FEAT:  feat_q  <= wr_data & FEAT_MASK;
          SEL_EXT:   if (!ext_reject) ext_q <= wr_data & EXT_MASK;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (rd_sel)
      SEL_MODE:  rd_data = mode_q;
      SEL_FADDR: rd_data = faddr_q;
      SEL_TBASE: rd_data = tbase_view;
      SEL_FEAT:  rd_data = feat_q;
      SEL_EXT:   rd_data = ext_q | (DW'(long_active) << 10);
      default:   rd_data = '0;
    endcase
  end

  // R4
  lme_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    paging_en |=> $stable(ext_q[8]));
  // R11
  pf_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pf_strobe |=> faddr_q == $past(pf_addr));
  // R5
  dbg_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_req && de && dbg_idx[2:1] == 2'b10) |=> ud_fault);
  // R5
  dbg_alias_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !de |-> (dbg_map != 3'd4 && dbg_map != 3'd5));
  // R9
  virt_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_virt && !ext_q[12]) |=> ud_fault);
  // R6
  gp_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gp_fault) |-> $past(wr_en || op_tsc || op_pmc));
endmodule

// File: tb/mode_ctl_unit_bench.sv
`timescale 1ns/1ps
module mode_ctl_unit_bench;
  localparam int CLK_NS = 20;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] priv_lvl = '0;
  logic wr_en = 0, pf_strobe = 0, dbg_req = 0, op_tsc = 0, op_pmc = 0, op_media = 0, op_virt = 0;
  logic [2:0] wr_sel = '0, rd_sel = '0, dbg_idx = '0;
  logic [31:0] wr_data = '0, pf_addr = '0;
  logic [31:0] rd_data, tbl_base;
  logic [2:0] dbg_map;
  logic ud_fault, gp_fault, prot_en, paging_en, pae_en, long_active, tbl_wt, tbl_cd;
  int checks = 0, fails = 0;

  always #(CLK_NS/2) clk = ~clk;

  mode_ctl_unit u_mode_ctl_unit (.*);

  // {sel, write data, expected readback}
  localparam logic [66:0] VEC [10] = '{
    {3'd0, 32'hFFFF_FFFF, 32'h8000_0001},
    {3'd0, 32'h0000_0000, 32'h0000_0000},
    {3'd3, 32'hFFFF_FFFF, 32'h0004_07FF},
    {3'd2, 32'hFFFF_FFFF, 32'hFFFF_FFF8},
    {3'd3, 32'h0000_0000, 32'h0000_0000},
    {3'd2, 32'hFFFF_FFFF, 32'hFFFF_F018},
    {3'd1, 32'h1234_5678, 32'h1234_5678},
    {3'd4, 32'hFFFF_FFFF, 32'h0000_7901},
    {3'd4, 32'h0000_0000, 32'h0000_0000},
    {3'd7, 32'hFFFF_FFFF, 32'h0000_0000}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic [31:0] d);
    @(negedge clk); wr_en = 1; wr_sel = sel; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  function automatic logic [31:0] rd(input logic [2:0] sel);
    rd_sel = sel;
    return 32'(0);
  endfunction

  task automatic rdchk(input string req, input logic [2:0] sel, input logic [31:0] exp);
    rd_sel = sel; #1;
    chk(req, rd_data, exp);
  endtask

  // request raised for one cycle; fault sampled the cycle after, then must drop
  task automatic pulse(input string req, input int kind, input logic exp_gp, input logic exp_ud);
    @(negedge clk);
    case (kind)
      0: op_tsc = 1; 1: op_pmc = 1; 2: op_media = 1; 3: op_virt = 1; default: dbg_req = 1;
    endcase
    @(negedge clk);
    op_tsc = 0; op_pmc = 0; op_media = 0; op_virt = 0; dbg_req = 0;
    chk(req, {30'd0, gp_fault, ud_fault}, {30'd0, exp_gp, exp_ud});
    @(negedge clk);
    chk(req, {30'd0, gp_fault, ud_fault}, 32'd0);
  endtask

  initial begin
    #(CLK_NS * 100000);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks + 1, fails);
    $finish;
  end

  initial begin
    void'(rd(3'd0));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    for (int s = 0; s < 8; s++) rdchk("R1", 3'(s), 32'd0);
    chk("R1", {tbl_base[31:0]}, 32'd0);
    chk("R1", {24'd0, prot_en, paging_en, pae_en, long_active, tbl_wt, tbl_cd, gp_fault, ud_fault}, 32'd0);

    // R2 field masks via vector table
    for (int i = 0; i < 10; i++) begin
      wr(VEC[i][66:64], VEC[i][63:32]);
      rdchk("R2", VEC[i][66:64], VEC[i][31:0]);
      chk("R2", {31'd0, gp_fault}, 32'd0);
    end

    // R10 alignment and cache controls
    wr(3'd2, 32'hABCD_E7F8);
    chk("R10", tbl_base, 32'hABCD_E000);
    chk("R10", {30'd0, tbl_cd, tbl_wt}, 32'd3);
    wr(3'd3, 32'h0000_0020);
    chk("R12", {31'd0, pae_en}, 32'd1);
    chk("R10", tbl_base, 32'hABCD_E7E0);
    rdchk("R10", 3'd2, 32'hABCD_E7F8);
    wr(3'd3, 32'h0);

    // R3 / R12 long-mode entry ordering
    wr(3'd4, 32'h0000_0100);
    chk("R3", {31'd0, long_active}, 32'd0);
    wr(3'd0, 32'h8000_0001);
    chk("R12", {30'd0, paging_en, prot_en}, 32'd3);
    chk("R3", {31'd0, long_active}, 32'd1);
    rdchk("R3", 3'd4, 32'h0000_0500);

    // R4 rejected change of long-mode enable while paging
    wr(3'd4, 32'h0000_0000);
    chk("R4", {31'd0, gp_fault}, 32'd1);
    rdchk("R4", 3'd4, 32'h0000_0500);
    chk("R4", {31'd0, long_active}, 32'd1);
    @(negedge clk);
    chk("R4", {31'd0, gp_fault}, 32'd0);
    wr(3'd4, 32'h0000_0900);
    chk("R4", {31'd0, gp_fault}, 32'd0);
    rdchk("R4", 3'd4, 32'h0000_0D00);
    wr(3'd0, 32'h0000_0001);
    chk("R3", {31'd0, long_active}, 32'd0);
    rdchk("R3", 3'd4, 32'h0000_0900);

    // R9 virtualization
    pulse("R9", 3, 0, 1);
    wr(3'd4, 32'h0000_1000);
    pulse("R9", 3, 0, 0);

    // R8 media
    pulse("R8", 2, 0, 1);
    wr(3'd3, 32'h0000_0200);
    pulse("R8", 2, 0, 0);

    // R6 timestamp, R7 counters (feature bit 2 and bit 8 clear here)
    priv_lvl = 2'd3;
    pulse("R6", 0, 0, 0);
    pulse("R7", 1, 1, 0);
    wr(3'd3, 32'h0000_0104);
    pulse("R6", 0, 1, 0);
    pulse("R7", 1, 0, 0);
    priv_lvl = 2'd0;
    pulse("R6", 0, 0, 0);

    // R5 debug aliasing
    dbg_idx = 3'd4; #1; chk("R5", {29'd0, dbg_map}, 32'd6);
    dbg_idx = 3'd5; #1; chk("R5", {29'd0, dbg_map}, 32'd7);
    dbg_idx = 3'd2; #1; chk("R5", {29'd0, dbg_map}, 32'd2);
    dbg_idx = 3'd5;
    pulse("R5", 4, 0, 0);
    wr(3'd3, 32'h0000_0008);
    dbg_idx = 3'd4; #1; chk("R5", {29'd0, dbg_map}, 32'd4);
    pulse("R5", 4, 0, 1);
    dbg_idx = 3'd6;
    pulse("R5", 4, 0, 0);

    // R11 page-fault capture wins over write
    @(negedge clk);
    pf_strobe = 1; pf_addr = 32'hDEAD_BEEF;
    wr_en = 1; wr_sel = 3'd1; wr_data = 32'h1111_2222;
    @(negedge clk);
    pf_strobe = 0; wr_en = 0;
    rdchk("R11", 3'd1, 32'hDEAD_BEEF);
    wr(3'd1, 32'h0000_0040);
    rdchk("R11", 3'd1, 32'h0000_0040);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule